// File: doc/BRIEF.md
# Self-Test and Address-Remap Repair Controller

This block sits between a user port and a small single-port SRAM (32 words of 12 bits by default, with the array itself outside the block). When the mode select is high and `start` is pulsed, it runs a stuck-at self-test over every word. Each address gets an all-zero write and read-back, then an all-one write and read-back. A word that fails either compare is recorded in a small table of failing addresses. No spare rows or columns exist. Repair works by renumbering: after the test, logical address N goes to the N-th healthy physical word, counting upward from physical word 0. The usable capacity therefore shrinks by one word for each failing word.

When the mode select is low and no test is running, user accesses go through the address remap to the SRAM. Read data returns from the array on the user output. An access whose logical address is at or above the usable-word count is flagged and is not passed to the SRAM. If more words fail than the table can hold, the run stops early and a repair-fail flag is raised. The usable count then drops to zero. The table is cleared at reset and again at the start of every run.

Top module: `bist_remap_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `sram_err` and `repair_fail` are 0, `err_addr` is 0, `usable_cnt` equals the word count (32), and logical addresses map one-to-one onto the same physical addresses.
- R2: A `start` pulse while `test_mode` is 1 and the block is idle makes `busy` 1 on the next cycle. A `start` pulse while `test_mode` is 0 is ignored.
- R3: For each address in ascending order, the test writes all zeros, reads the word back and compares it with zero. It then writes all ones (0xFFF), reads the word back and compares it with all ones. A word that fails either compare is marked as faulty.
- R4: On any failed compare, `sram_err` goes to 1 and `err_addr` shows the failing address. At the end of a run, `err_addr` holds the last failing address found. Both are cleared at the next start.
- R5: At the end of a run, `busy` falls and `done` rises on the same edge. `done` stays 1 until the next start, and `busy` and `done` are never 1 together.
- R6: Up to MAX_MARKS (4) failing words are marked. A further failing word sets `repair_fail`, ends the run on that compare, forces `usable_cnt` to 0, and makes every user access out of range.
- R7: After a run without repair failure, a user access to logical address N reaches the N-th healthy physical word, counting from 0 in ascending physical order.
- R8: `usable_cnt` equals 32 minus the number of marked words. A user access whose address is at or above `usable_cnt` raises `usr_oor` in that cycle, and neither `mem_we` nor `mem_re` is asserted for it.
- R9: In normal mode, an in-range user write stores `usr_wdata`. A read of the same logical address returns that value on `usr_rdata` in the cycle after `usr_re`.
- R10: While `busy` is 1, user accesses do not reach the SRAM. Every SRAM write carries 0x000 or 0xFFF, and `usr_rdata` is 0.
- R11: Each run rebuilds the table from scratch. A fault-free run after a failed one gives `usable_cnt` 32, with `repair_fail` and `sram_err` both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | 1 selects the self-test path, 0 the user path |
| start | input | 1 | Starts a test run (honoured only with test_mode = 1) |
| busy | output | 1 | A test run is in progress |
| done | output | 1 | The last run has finished; held until the next start |
| sram_err | output | 1 | At least one compare failed in the current or last run |
| err_addr | output | 5 | Most recent failing physical address |
| repair_fail | output | 1 | More failing words than the table holds |
| usable_cnt | output | 6 | Number of usable logical words |
| usr_addr | input | 5 | User logical address |
| usr_wdata | input | 12 | User write data |
| usr_we | input | 1 | User write enable |
| usr_re | input | 1 | User read enable |
| usr_rdata | output | 12 | User read data (one cycle after usr_re) |
| usr_oor | output | 1 | Current user access is out of the usable range |
| mem_addr | output | 5 | SRAM physical address |
| mem_wdata | output | 12 | SRAM write data |
| mem_we | output | 1 | SRAM write enable |
| mem_re | output | 1 | SRAM read enable (data registered by the SRAM) |
| mem_rdata | input | 12 | SRAM read data |

## Verification
The bench drives an SRAM model with stuck-at bit masks and puts faulty words at the corners: word 0, caught by the zero read-back, and word 31, caught only by the ones read-back. A controller that skipped either phase or ended one address early would miss one of them. A run of adjacent faulty words checks that the remap steps over consecutive holes; a remap that added only one offset per comparison would send two logical words to the same physical word, and the read-back sweep would see corrupted data. A fifth fault checks the early stop and the forced zero capacity. A clean run after it shows whether stale table entries survive. User writes of a non-pattern value held throughout each run would show up on the SRAM port if the block did not shut out user accesses while busy.

// File: rtl/bist_remap_pkg.sv
// Package: shared state encoding for the self-test sequencer.
// Assumes a single-port SRAM with one-cycle registered read.
package bist_remap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W0,
        ST_R0,
        ST_C0,
        ST_W1,
        ST_R1,
        ST_C1
    } bist_st_e;

endpackage

// File: rtl/bist_seq.sv
// Module: bist_seq
// Walks every SRAM address in ascending order, writing and reading back
// all zeros and then all ones, and reports each failing word.
// Assumes read data is valid in the cycle after the read strobe and that
// the mark table holds failing addresses in the order they are reported.
module bist_seq
    import bist_remap_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              full_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] b_addr_o,
    output logic [DATA_W-1:0] b_wdata_o,
    output logic              b_we_o,
    output logic              b_re_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              clr_o,
    output logic              rec_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic              rfail_o
);

    localparam logic [DATA_W-1:0] ONES = '1;
    localparam logic [DATA_W-1:0] ZERO = '0;

    bist_st_e          state, state_nx;
    logic [ADDR_W-1:0] addr;
    logic              chk, bad, adv, last, stop;

    // Compare decode: which cycle checks data and what it expects
    always_comb begin
        chk  = (state == ST_C0) || (state == ST_C1);
        bad  = chk && (rdata_i != ((state == ST_C1) ? ONES : ZERO));
        adv  = bad || (state == ST_C1);
        last = &addr;
        stop = bad && full_i;
    end

    // Next-state selection for the per-address write/read/compare walk
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (go_i) state_nx = ST_W0;
            ST_W0:   state_nx = ST_R0;
            ST_R0:   state_nx = ST_C0;
            ST_W1:   state_nx = ST_R1;
            ST_R1:   state_nx = ST_C1;
            ST_C0, ST_C1: begin
                if (stop)            state_nx = ST_IDLE;
                else if (!adv)       state_nx = ST_W1;
                else if (last)       state_nx = ST_IDLE;
                else                 state_nx = ST_W0;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Address counter: restart on go, step after each finished word
    always_ff @(posedge clk) begin
        if (!rst_n || clr_o)                     addr <= '0;
        else if (chk && adv && !last && !stop)   addr <= addr + 1'b1;
    end

    // Run result flags: cleared on start, set by compare outcomes
    always_ff @(posedge clk) begin
        if (!rst_n || clr_o) begin
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            err_addr_o <= '0;
            rfail_o    <= 1'b0;
        end else begin
            if (chk && (stop || (adv && last))) done_o <= 1'b1;
            if (bad) begin
                err_o      <= 1'b1;
                err_addr_o <= addr;
            end
            if (stop) rfail_o <= 1'b1;
        end
    end

    // Memory strobes and table controls decoded from the state
    always_comb begin
        clr_o     = (state == ST_IDLE) && go_i;
        rec_o     = bad && !full_i;
        busy_o    = (state != ST_IDLE);
        b_addr_o  = addr;
        b_we_o    = (state == ST_W0) || (state == ST_W1);
        b_re_o    = (state == ST_R0) || (state == ST_R1);
        b_wdata_o = (state == ST_W1) ? ONES : ZERO;
    end

endmodule

// File: rtl/mark_table.sv
// Module: mark_table
// Holds the failing physical addresses and turns a logical address into
// the physical address of the matching healthy word.
// Assumes entries arrive in strictly ascending address order, so the
// remap can step over them in one pass.
module mark_table #(
    parameter int ADDR_W    = 5,
    parameter int MAX_MARKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              rec_i,
    input  logic [ADDR_W-1:0] rec_addr_i,
    input  logic              rfail_i,
    input  logic [ADDR_W-1:0] lg_addr_i,
    output logic [ADDR_W-1:0] ph_addr_o,
    output logic              in_range_o,
    output logic [ADDR_W:0]   usable_o,
    output logic              full_o
);

    localparam int              CNT_W   = $clog2(MAX_MARKS + 1);
    localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W + 1)'(1 << ADDR_W);

    logic [ADDR_W-1:0] slot [MAX_MARKS];
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W:0]   walk;

    // Entry count: cleared per run, bumped on each accepted mark
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                      cnt <= '0;
        else if (rec_i && !full_o)                cnt <= cnt + 1'b1;
    end

    // One register per table slot, loaded when it is the next free one
    for (genvar g = 0; g < MAX_MARKS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i)                                slot[g] <= '0;
            else if (rec_i && (cnt == CNT_W'(g)))               slot[g] <= rec_addr_i;
        end
    end

    // Remap: step the logical index past every marked word at or below it
    always_comb begin
        walk = {1'b0, lg_addr_i};
        for (int i = 0; i < MAX_MARKS; i++) begin
            if ((CNT_W'(i) < cnt) && ({1'b0, slot[i]} <= walk))
                walk = walk + (ADDR_W + 1)'(1);
        end
    end

    // Capacity and range outputs
    always_comb begin
        full_o     = (cnt == CNT_W'(MAX_MARKS));
        usable_o   = rfail_i ? '0 : (DEPTH_V - (ADDR_W + 1)'(cnt));
        in_range_o = ({1'b0, lg_addr_i} < usable_o);
        ph_addr_o  = walk[ADDR_W-1:0];
    end

endmodule

// File: rtl/access_mux.sv
// Module: access_mux
// Chooses between the self-test and user paths towards the SRAM and
// gates user read data and out-of-range accesses.
// Assumes the user address has already been remapped.
module access_mux #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 12
) (
    input  logic              sel_bist_i,
    input  logic [ADDR_W-1:0] b_addr_i,
    input  logic [DATA_W-1:0] b_wdata_i,
    input  logic              b_we_i,
    input  logic              b_re_i,
    input  logic [ADDR_W-1:0] u_addr_i,
    input  logic [DATA_W-1:0] u_wdata_i,
    input  logic              u_we_i,
    input  logic              u_re_i,
    input  logic              in_range_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [DATA_W-1:0] u_rdata_o,
    output logic              u_oor_o
);

    // Path selection and range gating
    always_comb begin
        u_oor_o     = !sel_bist_i && (u_we_i || u_re_i) && !in_range_i;
        mem_addr_o  = sel_bist_i ? b_addr_i  : u_addr_i;
        mem_wdata_o = sel_bist_i ? b_wdata_i : u_wdata_i;
        mem_we_o    = sel_bist_i ? b_we_i    : (u_we_i && in_range_i);
        mem_re_o    = sel_bist_i ? b_re_i    : (u_re_i && in_range_i);
        u_rdata_o   = sel_bist_i ? '0        : mem_rdata_i;
    end

endmodule

// File: rtl/bist_remap_ctrl.sv
// Module: bist_remap_ctrl (top)
// Stuck-at self-test of an external single-port SRAM, with repair done by
// renumbering logical addresses onto the healthy physical words.
// Assumes a one-cycle registered SRAM read and a synchronous active-low reset.
module bist_remap_ctrl #(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 12,
    parameter int MAX_MARKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              sram_err,
    output logic [ADDR_W-1:0] err_addr,
    output logic              repair_fail,
    output logic [ADDR_W:0]   usable_cnt,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [DATA_W-1:0] usr_wdata,
    input  logic              usr_we,
    input  logic              usr_re,
    output logic [DATA_W-1:0] usr_rdata,
    output logic              usr_oor,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic [ADDR_W-1:0] b_addr, ph_addr;
    logic [DATA_W-1:0] b_wdata;
    logic              b_we, b_re, clr, rec, full, in_range, sel_bist;

    // The test path owns the SRAM when selected or while a run is active
    assign sel_bist = test_mode || busy;

    bist_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (start && test_mode),
        .full_i     (full),
        .rdata_i    (mem_rdata),
        .b_addr_o   (b_addr),
        .b_wdata_o  (b_wdata),
        .b_we_o     (b_we),
        .b_re_o     (b_re),
        .busy_o     (busy),
        .done_o     (done),
        .clr_o      (clr),
        .rec_o      (rec),
        .err_o      (sram_err),
        .err_addr_o (err_addr),
        .rfail_o    (repair_fail)
    );

    mark_table #(.ADDR_W(ADDR_W), .MAX_MARKS(MAX_MARKS)) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .rec_i      (rec),
        .rec_addr_i (b_addr),
        .rfail_i    (repair_fail),
        .lg_addr_i  (usr_addr),
        .ph_addr_o  (ph_addr),
        .in_range_o (in_range),
        .usable_o   (usable_cnt),
        .full_o     (full)
    );

    access_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .sel_bist_i  (sel_bist),
        .b_addr_i    (b_addr),
        .b_wdata_i   (b_wdata),
        .b_we_i      (b_we),
        .b_re_i      (b_re),
        .u_addr_i    (ph_addr),
        .u_wdata_i   (usr_wdata),
        .u_we_i      (usr_we),
        .u_re_i      (usr_re),
        .in_range_i  (in_range),
        .mem_rdata_i (mem_rdata),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_re_o    (mem_re),
        .u_rdata_o   (usr_rdata),
        .u_oor_o     (usr_oor)
    );

endmodule

// File: rtl/bist_remap_chk.sv
// Module: bist_remap_chk
// Temporal checks on the controller's ports, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module bist_remap_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_mode,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              sram_err,
    input logic              repair_fail,
    input logic [ADDR_W:0]   usable_cnt,
    input logic [ADDR_W-1:0] usr_addr,
    input logic              usr_we,
    input logic              usr_re,
    input logic              usr_oor,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              mem_re
);

    localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W + 1)'(1 << ADDR_W);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && test_mode && !busy) |=> busy); // R2
    AST_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R5
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R5
    AST_FAIL_ZERO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        repair_fail |-> (sram_err && usable_cnt == '0)); // R6
    AST_OOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && !busy && usr_oor) |-> (!mem_we && !mem_re)); // R8
    AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        usable_cnt <= DEPTH_V); // R8
    AST_REMAP_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && !busy && (usr_we || usr_re) && !usr_oor) |-> (mem_addr >= usr_addr)); // R7
    AST_BUSY_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |-> (mem_wdata == '0 || mem_wdata == '1)); // R10

endmodule

bind bist_remap_ctrl bist_remap_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bist_remap_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_mode   (test_mode),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .sram_err    (sram_err),
    .repair_fail (repair_fail),
    .usable_cnt  (usable_cnt),
    .usr_addr    (usr_addr),
    .usr_we      (usr_we),
    .usr_re      (usr_re),
    .usr_oor     (usr_oor),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we),
    .mem_re      (mem_re)
);

// File: tb/test_bist_remap_ctrl.sv
// Bench: stuck-at SRAM model, fault scenarios, full logical sweeps.
module test_bist_remap_ctrl;

    localparam int AW = 5;
    localparam int DW = 12;
    localparam int NW = 32;
    localparam int MK = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_mode = 1'b0, start = 1'b0;
    logic          busy, done, sram_err, repair_fail, usr_oor;
    logic [AW-1:0] err_addr, mem_addr;
    logic [AW:0]   usable_cnt;
    logic [AW-1:0] usr_addr = '0;
    logic [DW-1:0] usr_wdata = '0, usr_rdata, mem_wdata, mem_rdata;
    logic          usr_we = 1'b0, usr_re = 1'b0, mem_we, mem_re;

    logic [DW-1:0] mem [NW];
    logic [DW-1:0] s0  [NW];
    logic [DW-1:0] s1  [NW];

    int n_total = 0;
    int n_bad   = 0;

    always #5 clk = ~clk;

    bist_remap_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MAX_MARKS(MK)) i_bist_remap_ctrl (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
        .busy(busy), .done(done), .sram_err(sram_err), .err_addr(err_addr),
        .repair_fail(repair_fail), .usable_cnt(usable_cnt),
        .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_we(usr_we), .usr_re(usr_re),
        .usr_rdata(usr_rdata), .usr_oor(usr_oor),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata)
    );

    // SRAM model with per-word stuck-at-0 / stuck-at-1 masks on read
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= (mem[mem_addr] & ~s0[mem_addr]) | s1[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_bad(input int p);
        return (s0[p] | s1[p]) != '0;
    endfunction

    function automatic int exp_phys(input int lg);
        int seen = 0;
        for (int p = 0; p < NW; p++) begin
            if (!is_bad(p)) begin
                if (seen == lg) return p;
                seen++;
            end
        end
        return -1;
    endfunction

    function automatic logic [DW-1:0] pat(input int lg);
        return DW'(lg * 149 + 7);
    endfunction

    task automatic clear_faults();
        for (int i = 0; i < NW; i++) begin
            s0[i] = '0;
            s1[i] = '0;
        end
    endtask

    // Run one test with user writes held on to probe the busy lock-out
    task automatic run_test(input string name);
        int viol = 0;
        int waited = 0;
        @(negedge clk);
        test_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; test_mode = 1'b0;
        chk(busy === 1'b1 && done === 1'b0, {name, " R2 busy after start"}, int'(busy), 1);
        usr_we = 1'b1; usr_re = 1'b1; usr_addr = 5'd7; usr_wdata = 12'h5A5;
        while (busy === 1'b1 && waited < 2000) begin
            if (mem_we && !(mem_wdata == 12'h000 || mem_wdata == 12'hFFF)) viol++;
            if (usr_rdata !== '0) viol++;
            @(negedge clk);
            waited++;
        end
        usr_we = 1'b0; usr_re = 1'b0;
        chk(waited < 2000, {name, " R5 run ends"}, waited, 0);
        chk(viol == 0, {name, " R10 user locked out while busy"}, viol, 0);
        chk(done === 1'b1, {name, " R5 done at end"}, int'(done), 1);
    endtask

    // Compare results with the fault map and sweep all logical addresses
    task automatic verify(input string name);
        int nb = 0;
        int lastbad = 0;
        int fifth = 0;
        int exp_use;
        bit fail;
        for (int p = 0; p < NW; p++) begin
            if (is_bad(p)) begin
                nb++;
                if (nb <= MK + 1) lastbad = p;
                if (nb == MK + 1) fifth = p;
            end
        end
        fail = (nb > MK);
        exp_use = fail ? 0 : NW - nb;
        chk(repair_fail === fail, {name, " R6 repair_fail"}, int'(repair_fail), int'(fail));
        chk(sram_err === (nb > 0), {name, " R4 sram_err"}, int'(sram_err), int'(nb > 0));
        if (nb > 0)
            chk(int'(err_addr) == (fail ? fifth : lastbad), {name, " R4 err_addr"},
                int'(err_addr), fail ? fifth : lastbad);
        chk(int'(usable_cnt) == exp_use, {name, " R8 usable_cnt"}, int'(usable_cnt), exp_use);
        repeat (3) @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0, {name, " R5 done held"}, int'(done), 1);
        // write sweep: range flag, remapped address, gating
        for (int lg = 0; lg < NW; lg++) begin
            usr_addr = AW'(lg); usr_wdata = pat(lg); usr_we = 1'b1;
            #1;
            if (lg < exp_use) begin
                chk(usr_oor === 1'b0 && mem_we === 1'b1, {name, " R8 in range"}, int'(usr_oor), 0);
                chk(int'(mem_addr) == exp_phys(lg), {name, " R7 remap"}, int'(mem_addr), exp_phys(lg));
            end else begin
                chk(usr_oor === 1'b1 && mem_we === 1'b0 && mem_re === 1'b0,
                    {name, " R8 out of range gated"}, int'(mem_we), 0);
            end
            @(negedge clk);
        end
        usr_we = 1'b0;
        // read sweep: data returns one cycle after the read
        for (int lg = 0; lg < exp_use; lg++) begin
            usr_addr = AW'(lg); usr_re = 1'b1;
            @(negedge clk);
            usr_re = 1'b0;
            chk(usr_rdata === pat(lg), {name, " R9 read back"}, int'(usr_rdata), int'(pat(lg)));
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        clear_faults();
        for (int i = 0; i < NW; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0 && done === 1'b0, "R1 busy/done idle", int'(busy), 0);
        chk(sram_err === 1'b0 && repair_fail === 1'b0 && err_addr === '0, "R1 flags clear",
            int'(sram_err), 0);
        chk(int'(usable_cnt) == NW, "R1 usable_cnt", int'(usable_cnt), NW);
        usr_addr = 5'd17; usr_re = 1'b1; #1;
        chk(int'(mem_addr) == 17 && usr_oor === 1'b0, "R1 identity map", int'(mem_addr), 17);
        @(negedge clk); usr_re = 1'b0;
        // R2 start ignored without test mode
        start = 1'b1; test_mode = 1'b0;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R2 start ignored in normal mode", int'(busy), 0);

        run_test("clean");
        verify("clean");

        clear_faults();
        s1[0]  = 12'h001;   // seen only by the zero read-back (R3)
        s0[31] = 12'h800;   // seen only by the ones read-back (R3)
        run_test("edges");
        verify("edges R3");

        clear_faults();
        s1[3] = 12'h010; s0[4] = 12'h100; s1[5] = 12'h400; s0[20] = 12'h002;
        run_test("adjacent");
        verify("adjacent R7");

        clear_faults();
        s1[2] = 12'h001; s0[9] = 12'h020; s0[10] = 12'h004; s1[15] = 12'h080; s1[27] = 12'h200;
        s0[30] = 12'h001;
        run_test("overflow");
        verify("overflow R6");

        clear_faults();
        run_test("rebuild");
        verify("rebuild R11");

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule